// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the state capture a processor core needs at the moment it enters an exception handler. When the core raises a general exception, the block records the faulting program counter, the cause code and, when present, the faulting virtual address. It marks the core as being in exception mode and reports which handler vector to use. When the core raises a debug exception, the block gates the request against the current interrupt level. If the request is accepted, it records the debug cause, the program counter and the previous status word, and it raises the interrupt level to the configured debug level.

The block owns the status word. The core updates the status word through a load strobe during normal execution. An exception or debug entry always takes priority over that load. Every update lands on one clock edge. A one-cycle vector strobe then tells the fetch logic where to go next. The same edge also updates the saved-state outputs, so the core can read them in the following cycle.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, every saved-state output and the status word read zero, and the vector strobe is low.
- R2: A general exception taken with the exception-mode bit clear and the user-mode bit (status bit 5) set selects vector code 1 (user) and stores the PC in the level-1 EPC.
- R3: A general exception taken with both the exception-mode bit (status bit 4) and the user-mode bit clear selects vector code 0 (kernel) and stores the PC in the level-1 EPC.
- R4: A general exception taken while the exception-mode bit is already set selects vector code 2 (double) and stores the PC in DEPC, and the level-1 EPC is left unchanged.
- R5: Every accepted general exception loads the cause code into the cause register and sets the exception-mode bit. All other status bits keep their values.
- R6: The faulting address register is loaded only when the exception carries the address-valid flag. Otherwise it keeps its value.
- R7: A debug request is accepted only when the interrupt level (status bits 3:0) is strictly below the debug level. A rejected request changes no register and raises no vector strobe.
- R8: An accepted debug entry selects vector code 3 (debug). It stores the debug cause, stores the PC in the debug-level EPC and copies the old status word into the debug-level EPS. It also sets the interrupt-level field to the debug level and sets the exception-mode bit, and the user-mode bit and the upper bits are kept.
- R9: When a general request and an accepted debug request arrive in the same cycle, the debug entry is taken and the cause register is untouched. When the debug request is rejected, the general exception proceeds.
- R10: All updates appear on the clock edge after the request, and the vector strobe is high for exactly that one cycle per entry.
- R11: The status load takes effect only in a cycle with no entry. An entry in the same cycle overrides the load.
- R12: When built without a DEPC register, a double exception stores the PC in the level-1 EPC and the DEPC output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | Cause code of the general exception |
| exc_vaddr_vld | input | 1 | Exception carries a faulting address |
| exc_vaddr | input | XLEN | Faulting virtual address |
| fault_pc | input | XLEN | PC of the excepting instruction |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause bits |
| ps_load | input | 1 | Load the status word from ps_load_val |
| ps_load_val | input | PS_W | New status word from the core |
| vec_valid | output | 1 | One-cycle strobe: a vector was selected |
| vec_id | output | 2 | 0 kernel, 1 user, 2 double, 3 debug |
| ps | output | PS_W | Current status word |
| epc1 | output | XLEN | Level-1 exception PC |
| epc_dbg | output | XLEN | Exception PC for the debug level |
| depc | output | XLEN | Double-exception PC |
| eps_dbg | output | PS_W | Saved status word for the debug level |
| exccause | output | CAUSE_W | Last general exception cause |
| excvaddr | output | XLEN | Last faulting virtual address |
| debugcause | output | DCAUSE_W | Last debug cause |

## Verification
The vector choice is driven through every combination of the exception-mode and user-mode bits, which separates the kernel, user and double paths. Mixed status words with the upper bits set show that only the intended bits are modified. The interrupt level is placed one step below the debug level and exactly at it, which pins down the strict comparison. Combined requests are tried with the debug gate both open and closed, which separates the priority rule from the gating rule. A second instance built without DEPC receives the same double-exception stimulus, so the two storage variants can be told apart.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [1:0] {
      VEC_KERNEL = 2'd0,
      VEC_USER   = 2'd1,
      VEC_DOUBLE = 2'd2,
      VEC_DEBUG  = 2'd3
   } vec_e;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_GEN  = 2'd1,
      EV_DBG  = 2'd2
   } ev_e;
endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
   import exc_entry_pkg::*;
#(
   parameter int ILVL_W      = 4,
   parameter int DEBUG_LEVEL = 6
) (
   input  logic              exc_req,
   input  logic              dbg_req,
   input  logic              excm,
   input  logic              um,
   input  logic [ILVL_W-1:0] ilvl,
   output ev_e               ev,
   output vec_e              vec
);
   localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DEBUG_LEVEL);

   logic dbg_ok;
   assign dbg_ok = dbg_req && (ilvl < DBG_LVL);

   always_comb begin
      ev  = EV_NONE;
      vec = VEC_KERNEL;
      if (dbg_ok) begin
         ev  = EV_DBG;
         vec = VEC_DEBUG;
      end else if (exc_req) begin
         ev = EV_GEN;
         if (excm)    vec = VEC_DOUBLE;
         else if (um) vec = VEC_USER;
         else         vec = VEC_KERNEL;
      end
   end
endmodule

// File: rtl/exc_entry_psnext.sv
module exc_entry_psnext
   import exc_entry_pkg::*;
#(
   parameter int PS_W        = 8,
   parameter int ILVL_W      = 4,
   parameter int EXCM_BIT    = 4,
   parameter int DEBUG_LEVEL = 6
) (
   input  ev_e             ev,
   input  logic [PS_W-1:0] ps_cur,
   input  logic            ps_load,
   input  logic [PS_W-1:0] ps_load_val,
   output logic [PS_W-1:0] ps_nxt
);
   localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DEBUG_LEVEL);

   always_comb begin
      ps_nxt = ps_cur;
      case (ev)
         EV_GEN: ps_nxt[EXCM_BIT] = 1'b1;
         EV_DBG: begin
            ps_nxt[ILVL_W-1:0] = DBG_LVL;
            ps_nxt[EXCM_BIT]   = 1'b1;
         end
         default: if (ps_load) ps_nxt = ps_load_val;
      endcase
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int CAUSE_W     = 6,
   parameter int DCAUSE_W    = 6,
   parameter int PS_W        = 8,
   parameter int ILVL_W      = 4,
   parameter int EXCM_BIT    = 4,
   parameter int UM_BIT      = 5,
   parameter int DEBUG_LEVEL = 6,
   parameter bit HAS_DEPC    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                exc_req,
   input  logic [CAUSE_W-1:0]  exc_cause,
   input  logic                exc_vaddr_vld,
   input  logic [XLEN-1:0]     exc_vaddr,
   input  logic [XLEN-1:0]     fault_pc,
   input  logic                dbg_req,
   input  logic [DCAUSE_W-1:0] dbg_cause,
   input  logic                ps_load,
   input  logic [PS_W-1:0]     ps_load_val,
   output logic                vec_valid,
   output logic [1:0]          vec_id,
   output logic [PS_W-1:0]     ps,
   output logic [XLEN-1:0]     epc1,
   output logic [XLEN-1:0]     epc_dbg,
   output logic [XLEN-1:0]     depc,
   output logic [PS_W-1:0]     eps_dbg,
   output logic [CAUSE_W-1:0]  exccause,
   output logic [XLEN-1:0]     excvaddr,
   output logic [DCAUSE_W-1:0] debugcause
);
   // elaboration-time parameter checks
   if (DEBUG_LEVEL < 2 || DEBUG_LEVEL > 6) begin : g_bad_level
      $error("DEBUG_LEVEL must lie in 2..6");
   end
   if ((1 << ILVL_W) <= DEBUG_LEVEL) begin : g_bad_ilvl
      $error("ILVL_W too narrow for DEBUG_LEVEL");
   end
   if (EXCM_BIT < ILVL_W || UM_BIT < ILVL_W || EXCM_BIT == UM_BIT ||
       EXCM_BIT >= PS_W || UM_BIT >= PS_W) begin : g_bad_layout
      $error("status word field layout overlaps or overflows");
   end

   ev_e             ev;
   vec_e            vec;
   logic [PS_W-1:0] ps_q, ps_d;
   logic            gen_take, dbg_take, epc1_we;

   exc_entry_arb #(.ILVL_W(ILVL_W), .DEBUG_LEVEL(DEBUG_LEVEL)) u_arb (
      .exc_req (exc_req),
      .dbg_req (dbg_req),
      .excm    (ps_q[EXCM_BIT]),
      .um      (ps_q[UM_BIT]),
      .ilvl    (ps_q[ILVL_W-1:0]),
      .ev      (ev),
      .vec     (vec)
   );

   exc_entry_psnext #(.PS_W(PS_W), .ILVL_W(ILVL_W), .EXCM_BIT(EXCM_BIT),
                      .DEBUG_LEVEL(DEBUG_LEVEL)) u_psn (
      .ev          (ev),
      .ps_cur      (ps_q),
      .ps_load     (ps_load),
      .ps_load_val (ps_load_val),
      .ps_nxt      (ps_d)
   );

   assign gen_take = (ev == EV_GEN);
   assign dbg_take = (ev == EV_DBG);
   assign epc1_we  = gen_take && (!ps_q[EXCM_BIT] || !HAS_DEPC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q       <= '0;
         vec_valid  <= 1'b0;
         vec_id     <= '0;
         epc1       <= '0;
         epc_dbg    <= '0;
         eps_dbg    <= '0;
         exccause   <= '0;
         excvaddr   <= '0;
         debugcause <= '0;
      end else begin
         ps_q      <= ps_d;
         vec_valid <= gen_take || dbg_take;
         if (gen_take || dbg_take) vec_id <= vec;
         if (epc1_we) epc1 <= fault_pc;
         if (gen_take) begin
            exccause <= exc_cause;
            if (exc_vaddr_vld) excvaddr <= exc_vaddr;
         end
         if (dbg_take) begin
            debugcause <= dbg_cause;
            epc_dbg    <= fault_pc;
            eps_dbg    <= ps_q;
         end
      end
   end

   if (HAS_DEPC) begin : g_depc
      logic [XLEN-1:0] depc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         depc_q <= '0;
         else if (gen_take && ps_q[EXCM_BIT]) depc_q <= fault_pc;
      end
      assign depc = depc_q;
   end else begin : g_no_depc
      assign depc = '0;
   end

   assign ps = ps_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int CAUSE_W     = 6,
   parameter int DCAUSE_W    = 6,
   parameter int ILVL_W      = 4,
   parameter int DEBUG_LEVEL = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                exc_req,
   input logic [CAUSE_W-1:0]  exc_cause,
   input logic                dbg_req,
   input logic                vec_valid,
   input logic [1:0]          vec_id,
   input logic                ps_excm,
   input logic [ILVL_W-1:0]   ps_ilvl,
   input logic [CAUSE_W-1:0]  exccause,
   input logic [DCAUSE_W-1:0] debugcause
);
   localparam logic [ILVL_W-1:0] DBG_LVL = ILVL_W'(DEBUG_LEVEL);

   AST_ENTRY_SETS_EXCM: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ps_excm); // R5
   AST_CAUSE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !dbg_req) |=> (exccause == $past(exc_cause))); // R5
   AST_DOUBLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && !dbg_req && ps_excm) |=> (vec_valid && vec_id == 2'd2)); // R4
   AST_DEBUG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && !exc_req && ps_ilvl >= DBG_LVL) |=> (!vec_valid && $stable(debugcause))); // R7
   AST_DEBUG_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && vec_id == 2'd3) |-> (ps_ilvl == DBG_LVL)); // R8
   AST_DEBUG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && exc_req && ps_ilvl < DBG_LVL) |=> (vec_id == 2'd3 && $stable(exccause))); // R9
   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req && !dbg_req) |=> !vec_valid); // R10
endmodule

bind exc_entry_ctrl exc_entry_chk #(
   .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .ILVL_W(ILVL_W), .DEBUG_LEVEL(DEBUG_LEVEL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .exc_req    (exc_req),
   .exc_cause  (exc_cause),
   .dbg_req    (dbg_req),
   .vec_valid  (vec_valid),
   .vec_id     (vec_id),
   .ps_excm    (ps_q[EXCM_BIT]),
   .ps_ilvl    (ps_q[ILVL_W-1:0]),
   .exccause   (exccause),
   .debugcause (debugcause)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
   localparam int CLK_NS = 10;

   typedef struct packed {
      logic [3:0] req;
      logic [7:0] ps0;
      logic       ex;
      logic       dbg;
      logic       exp_v;
      logic [1:0] exp_vec;
      logic [7:0] exp_ps;
   } row_t;

   // status: [3:0] interrupt level, [4] exception mode, [5] user mode; debug level 6
   localparam row_t TBL [12] = '{
      '{4'd3,  8'h00, 1'b1, 1'b0, 1'b1, 2'd0, 8'h10},
      '{4'd2,  8'h20, 1'b1, 1'b0, 1'b1, 2'd1, 8'h30},
      '{4'd4,  8'h10, 1'b1, 1'b0, 1'b1, 2'd2, 8'h10},
      '{4'd4,  8'h30, 1'b1, 1'b0, 1'b1, 2'd2, 8'h30},
      '{4'd8,  8'h03, 1'b0, 1'b1, 1'b1, 2'd3, 8'h16},
      '{4'd7,  8'h26, 1'b0, 1'b1, 1'b0, 2'd0, 8'h26},
      '{4'd7,  8'h05, 1'b0, 1'b1, 1'b1, 2'd3, 8'h16},
      '{4'd9,  8'h07, 1'b1, 1'b1, 1'b1, 2'd0, 8'h17},
      '{4'd9,  8'h02, 1'b1, 1'b1, 1'b1, 2'd3, 8'h16},
      '{4'd5,  8'hC1, 1'b1, 1'b0, 1'b1, 2'd0, 8'hD1},
      '{4'd8,  8'hE4, 1'b0, 1'b1, 1'b1, 2'd3, 8'hF6},
      '{4'd10, 8'h00, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 1'b0, exc_vaddr_vld = 1'b0, dbg_req = 1'b0, ps_load = 1'b0;
   logic [5:0]  exc_cause = '0, dbg_cause = '0;
   logic [31:0] exc_vaddr = '0, fault_pc = '0;
   logic [7:0]  ps_load_val = '0;

   logic        vec_valid, nd_vec_valid;
   logic [1:0]  vec_id, nd_vec_id;
   logic [7:0]  ps, eps_dbg, nd_ps, nd_eps_dbg;
   logic [31:0] epc1, epc_dbg, depc, excvaddr;
   logic [31:0] nd_epc1, nd_epc_dbg, nd_depc, nd_excvaddr;
   logic [5:0]  exccause, debugcause, nd_exccause, nd_debugcause;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_NS/2) clk = ~clk;

   exc_entry_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
      .exc_vaddr_vld(exc_vaddr_vld), .exc_vaddr(exc_vaddr), .fault_pc(fault_pc),
      .dbg_req(dbg_req), .dbg_cause(dbg_cause), .ps_load(ps_load), .ps_load_val(ps_load_val),
      .vec_valid(vec_valid), .vec_id(vec_id), .ps(ps), .epc1(epc1), .epc_dbg(epc_dbg),
      .depc(depc), .eps_dbg(eps_dbg), .exccause(exccause), .excvaddr(excvaddr),
      .debugcause(debugcause)
   );

   exc_entry_ctrl #(.HAS_DEPC(1'b0)) u_dut_nd (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
      .exc_vaddr_vld(exc_vaddr_vld), .exc_vaddr(exc_vaddr), .fault_pc(fault_pc),
      .dbg_req(dbg_req), .dbg_cause(dbg_cause), .ps_load(ps_load), .ps_load_val(ps_load_val),
      .vec_valid(nd_vec_valid), .vec_id(nd_vec_id), .ps(nd_ps), .epc1(nd_epc1),
      .epc_dbg(nd_epc_dbg), .depc(nd_depc), .eps_dbg(nd_eps_dbg), .exccause(nd_exccause),
      .excvaddr(nd_excvaddr), .debugcause(nd_debugcause)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic load_ps(input logic [7:0] v);
      ps_load = 1'b1; ps_load_val = v;
      @(negedge clk);
      ps_load = 1'b0;
   endtask

   task automatic fire(input logic ex, input logic [5:0] c, input logic vv,
                       input logic [31:0] va, input logic dbg, input logic [5:0] dc,
                       input logic [31:0] pc);
      exc_req = ex; exc_cause = c; exc_vaddr_vld = vv; exc_vaddr = va;
      dbg_req = dbg; dbg_cause = dc; fault_pc = pc;
      @(negedge clk);
      exc_req = 1'b0; dbg_req = 1'b0; exc_vaddr_vld = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 100000);
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      // R1 reset state
      chk("R1 vec_valid", 32'(vec_valid), 0);
      chk("R1 ps", 32'(ps), 0);
      chk("R1 epc1", epc1, 0);
      chk("R1 depc", depc, 0);
      chk("R1 exccause", 32'(exccause), 0);
      chk("R1 debugcause", 32'(debugcause), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < 12; i++) begin
         load_ps(TBL[i].ps0);
         fire(TBL[i].ex, 6'(i + 1), 1'b0, 32'h0, TBL[i].dbg, 6'(i + 32), 32'h400 + 32'(i * 4));
         chk($sformatf("R%0d row %0d vec_valid", TBL[i].req, i), 32'(vec_valid), 32'(TBL[i].exp_v));
         if (TBL[i].exp_v)
            chk($sformatf("R%0d row %0d vec_id", TBL[i].req, i), 32'(vec_id), 32'(TBL[i].exp_vec));
         chk($sformatf("R%0d row %0d ps", TBL[i].req, i), 32'(ps), 32'(TBL[i].exp_ps));
      end

      // R3 kernel entry stores PC in level-1 EPC; R6 address not flagged
      load_ps(8'h00);
      fire(1'b1, 6'h1C, 1'b0, 32'hFFFF_0000, 1'b0, 6'h0, 32'h1000_0040);
      chk("R3 epc1", epc1, 32'h1000_0040);
      chk("R5 exccause", 32'(exccause), 32'h1C);
      chk("R6 excvaddr unchanged without flag", excvaddr, 32'h0);
      // R10 strobe lasts one cycle
      chk("R10 strobe high", 32'(vec_valid), 1);
      @(negedge clk);
      chk("R10 strobe low next cycle", 32'(vec_valid), 0);

      // R2 user entry stores PC in EPC1
      load_ps(8'h20);
      fire(1'b1, 6'h0A, 1'b0, 32'h0, 1'b0, 6'h0, 32'h1000_0080);
      chk("R2 epc1", epc1, 32'h1000_0080);

      // R6 address-carrying exception
      load_ps(8'h00);
      fire(1'b1, 6'h09, 1'b1, 32'hDEAD_BEE0, 1'b0, 6'h0, 32'h1000_0100);
      chk("R6 excvaddr", excvaddr, 32'hDEAD_BEE0);

      // R4 double exception; R12 variant without DEPC
      load_ps(8'h10);
      fire(1'b1, 6'h21, 1'b0, 32'h0, 1'b0, 6'h0, 32'h2000_0000);
      chk("R4 depc", depc, 32'h2000_0000);
      chk("R4 epc1 unchanged", epc1, 32'h1000_0100);
      chk("R12 epc1 takes pc", nd_epc1, 32'h2000_0000);
      chk("R12 depc zero", nd_depc, 32'h0);

      // R8 debug entry captures state
      load_ps(8'h23);
      fire(1'b0, 6'h0, 1'b0, 32'h0, 1'b1, 6'h2A, 32'h3000_0010);
      chk("R8 debugcause", 32'(debugcause), 32'h2A);
      chk("R8 epc_dbg", epc_dbg, 32'h3000_0010);
      chk("R8 eps_dbg", 32'(eps_dbg), 32'h23);
      chk("R8 ps", 32'(ps), 32'h36);

      // R7 rejected debug at the level leaves state alone
      load_ps(8'h06);
      fire(1'b0, 6'h0, 1'b0, 32'h0, 1'b1, 6'h11, 32'h3000_0020);
      chk("R7 debugcause unchanged", 32'(debugcause), 32'h2A);
      chk("R7 epc_dbg unchanged", epc_dbg, 32'h3000_0010);
      chk("R7 eps_dbg unchanged", 32'(eps_dbg), 32'h23);
      chk("R7 no strobe", 32'(vec_valid), 0);

      // R9 debug wins, cause register untouched
      load_ps(8'h00);
      fire(1'b1, 6'h3F, 1'b0, 32'h0, 1'b1, 6'h05, 32'h3000_0030);
      chk("R9 exccause unchanged", 32'(exccause), 32'h21);
      chk("R9 debugcause", 32'(debugcause), 32'h05);
      chk("R9 epc1 unchanged", epc1, 32'h1000_0100);

      // R11 entry overrides load, load alone applies
      load_ps(8'h00);
      ps_load = 1'b1; ps_load_val = 8'h2F;
      fire(1'b1, 6'h02, 1'b0, 32'h0, 1'b0, 6'h0, 32'h1000_0200);
      ps_load = 1'b0;
      chk("R11 entry beats load", 32'(ps), 32'h10);
      load_ps(8'h2F);
      chk("R11 load alone", 32'(ps), 32'h2F);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule